// File: doc/BRIEF.md
# Serial Register Read Port (Three-Wire, Turnaround Data Line)

This block is the slave side of a three-wire serial link: a serial clock, an enable strobe and one shared data line. A host controller uses it to read any of seven 24-bit registers held in a neighbouring register file.

While enable is high, the host clocks in a five-bit command frame. The frame holds a read flag followed by a four-bit register address. When enable falls, the port fetches the addressed word through a parallel read port and holds it in a shift register. The data line stays an input at that point. The first rising serial clock after that switches the line to an output and presents the word's top bit. The next rising edges walk down to the bottom bit. A separate enable high-then-low pulse then hands the line back to the host.

All three pins are sampled by the block's own system clock through a resynchronizer, and the port acts on the detected pin edges. The host's serial clock therefore has to be several times slower than the system clock. The tristate pin is represented by an output-enable and a data-out signal.

Top module: `srl_read_port`

## Requirements
- R1: After the asynchronous active-low reset, `sdio_oe` and `sdio_out` are 0 and the port is idle, waiting for enable to rise.
- R2: While `sen` is high, the port samples `sdio_in` on each rising `sclk`. The first bit is the command flag, with 1 meaning read. The next four bits are the address, most significant first. `rd_addr` shows those four address bits once the frame is complete.
- R3: When `sen` falls after a read frame of exactly five bits, the port loads the word at `rd_addr` into its shift register. `sdio_oe` stays 0 until the next rising `sclk`.
- R4: The first rising `sclk` after that load sets `sdio_oe` to 1, and `sdio_out` then carries bit 23 of the loaded word.
- R5: Each further rising `sclk` presents the next lower bit. Bit 0 appears after the 24th rising edge, counting the edge that turned the line around.
- R6: Rising `sclk` edges after the 24th keep `sdio_out` at bit 0. The output does not wrap or shift in other values.
- R7: After the transfer, `sdio_oe` stays 1 while `sen` is high again. It returns to 0 when `sen` falls at the end of that release pulse.
- R8: Address values 0 and 8 to 15 load 24 zero bits. The turnaround and the 24-edge sequence still run as for a valid address.
- R9: A frame whose command flag is 0, or that has fewer or more than five bits, starts no read. `sdio_oe` stays 0 through later `sclk` edges.
- R10: Asserting `rst_n` low in the middle of a transfer sets `sdio_oe` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sen | input | 1 | Enable strobe from the host |
| sdio_in | input | 1 | Data line as seen by the port when the host drives it |
| sdio_out | output | 1 | Value driven onto the data line |
| sdio_oe | output | 1 | 1 when the port drives the data line |
| rd_addr | output | 4 | Address presented to the register file read port |
| rd_data | input | 24 | Word returned by the register file for `rd_addr` |

## Verification
Every one of the sixteen address codes is read twice, with the register file returning a word pattern and then its bitwise complement. This separates correct bit order and alignment from stuck or swapped bits, and separates valid addresses (real data) from out-of-range ones (all zeros even though the file returns nonzero data). Each read also clocks two extra edges to tell saturation apart from wraparound, and checks the output-enable at the turnaround and at each step of the release pulse. Malformed frames are tried to show that a cleared read flag, a short frame and a long frame each leave the line released. A reset in mid-transfer tests that the line drops without waiting for a clock.

// File: rtl/srl_pkg.sv
package srl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FRAME   = 3'd1,
    ST_ARMED   = 3'd2,
    ST_SHIFT   = 3'd3,
    ST_RELEASE = 3'd4
  } port_state_e;

  // Address decode: only lo..hi name a real register.
  function automatic bit addr_in_range(input int unsigned addr,
                                       input int unsigned lo,
                                       input int unsigned hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

  // A frame starts a read only with the read flag set and the exact bit count.
  function automatic bit frame_is_read(input bit          read_flag,
                                       input int unsigned bits_seen,
                                       input int unsigned bits_needed);
    return read_flag && (bits_seen == bits_needed);
  endfunction

  // Saturating increment used by both bit counters.
  function automatic int unsigned sat_inc(input int unsigned value,
                                          input int unsigned limit);
    return (value >= limit) ? limit : value + 1;
  endfunction

endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] prev_q;

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= q;
  end

  assign rise = q & ~prev_q;
  assign fall = ~q & prev_q;

endmodule

// File: rtl/srl_frame_rx.sv
module srl_frame_rx #(
  parameter int CMD_W = 5,
  localparam int CNT_MAX = CMD_W + 1,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             din,
  output logic [CMD_W-1:0] frame,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      count <= '0;
    end else if (clear) begin
      frame <= '0;
      count <= '0;
    end else if (sample) begin
      frame <= {frame[CMD_W-2:0], din};
      count <= CNT_W'(srl_pkg::sat_inc(int'(count), CNT_MAX));
    end
  end

  AST_FRAME_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(CNT_MAX)) else $error("frame counter overran"); // R9

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0)) else $error("clear did not empty frame"); // R2

endmodule

// File: rtl/srl_shift_tx.sv
module srl_shift_tx #(
  parameter int DATA_W = 24,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              first_edge,
  input  logic              step,
  input  logic              release_evt,
  output logic [DATA_W-1:0] word,
  output logic [CNT_W-1:0]  bitcnt,
  output logic              oe,
  output logic              bit_out
);

  logic at_end;
  assign at_end = (bitcnt == CNT_W'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= '0;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else begin
      if (load) begin
        word   <= load_data;
        bitcnt <= '0;
      end else if (first_edge) begin
        oe     <= 1'b1;
        bitcnt <= CNT_W'(1);
      end else if (step && !at_end) begin
        word   <= {word[DATA_W-2:0], 1'b0};
        bitcnt <= CNT_W'(srl_pkg::sat_inc(int'(bitcnt), DATA_W));
      end
      if (release_evt) oe <= 1'b0;
    end
  end

  assign bit_out = oe & word[DATA_W-1];

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_end) |=> $stable(word)) else $error("shifter moved past last bit"); // R6

  AST_OE_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(first_edge)) else $error("line turned without clock edge"); // R4

  AST_OE_FALL_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(release_evt)) else $error("line released without pulse"); // R7

  AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CNT_W'(DATA_W)) else $error("bit counter overran"); // R5

endmodule

// File: rtl/srl_read_port.sv
module srl_read_port #(
  parameter int DATA_W      = 24,
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 7,
  parameter int SYNC_STAGES = 2,
  localparam int CMD_W      = ADDR_W + 1,
  localparam int FCNT_W     = $clog2(CMD_W + 2),
  localparam int BCNT_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sen,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  import srl_pkg::*;

  // Synchronized pins: bit 0 clock, bit 1 enable, bit 2 data.
  logic [2:0] pin_q, pin_rise, pin_fall;

  srl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sdio_in, sen, sclk}),
    .q     (pin_q),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  logic sclk_rise, en_rise, en_fall, din_q;
  assign sclk_rise = pin_rise[0];
  assign en_rise   = pin_rise[1];
  assign en_fall   = pin_fall[1];
  assign din_q     = pin_q[2];

  port_state_e state_q, state_d;

  // Named internal events.
  logic ev_clear, ev_sample, ev_load, ev_first, ev_step, ev_release;
  logic [CMD_W-1:0]  frame;
  logic [FCNT_W-1:0] frame_cnt;
  logic              read_ok, addr_ok;
  logic [DATA_W-1:0] load_word, tx_word;
  logic [BCNT_W-1:0] tx_bitcnt;

  assign rd_addr   = frame[ADDR_W-1:0];
  assign read_ok   = frame_is_read(frame[CMD_W-1], int'(frame_cnt), CMD_W);
  assign addr_ok   = addr_in_range(int'(rd_addr), 1, NUM_REGS);
  assign load_word = addr_ok ? rd_data : '0;

  always_comb begin
    state_d    = state_q;
    ev_clear   = 1'b0;
    ev_sample  = 1'b0;
    ev_load    = 1'b0;
    ev_first   = 1'b0;
    ev_step    = 1'b0;
    ev_release = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en_rise) begin
          ev_clear = 1'b1;
          state_d  = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (en_fall) begin
          if (read_ok) begin
            ev_load = 1'b1;
            state_d = ST_ARMED;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (sclk_rise) begin
          ev_sample = 1'b1;
        end
      end
      ST_ARMED: begin
        if (en_rise) begin
          ev_clear = 1'b1;
          state_d  = ST_FRAME;
        end else if (sclk_rise) begin
          ev_first = 1'b1;
          state_d  = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (en_rise) begin
          state_d = ST_RELEASE;
        end else if (sclk_rise) begin
          ev_step = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (en_fall) begin
          ev_release = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  srl_frame_rx #(.CMD_W(CMD_W)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ev_clear),
    .sample (ev_sample),
    .din    (din_q),
    .frame  (frame),
    .count  (frame_cnt)
  );

  srl_shift_tx #(.DATA_W(DATA_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (ev_load),
    .load_data   (load_word),
    .first_edge  (ev_first),
    .step        (ev_step),
    .release_evt (ev_release),
    .word        (tx_word),
    .bitcnt      (tx_bitcnt),
    .oe          (sdio_oe),
    .bit_out     (sdio_out)
  );

  AST_ARMED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED) |-> !sdio_oe) else $error("line driven before first edge"); // R3

  AST_DRIVE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (state_q == ST_SHIFT || state_q == ST_RELEASE)) else $error("line driven outside transfer"); // R9

  AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && !addr_ok) |=> (tx_word == '0)) else $error("out-of-range address loaded data"); // R8

  AST_FIRST_BIT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> (sdio_out == $past(tx_word[DATA_W-1]))) else $error("first bit is not the top bit"); // R4

  AST_NO_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAME && en_fall && !frame[CMD_W-1]) |=> (state_q == ST_IDLE)) else $error("non-read frame armed the port"); // R9

endmodule

// File: tb/tb_srl_read_port.sv
module tb_srl_read_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DW         = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0;
  logic          sen = 1'b0;
  logic          sdio_in = 1'b0;
  logic          sdio_out, sdio_oe;
  logic [3:0]    rd_addr;
  logic [DW-1:0] rd_data;
  bit            inv_sel = 1'b0;
  int            checks = 0;
  int            fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] reg_val(input logic [3:0] a, input bit inv);
    logic [DW-1:0] b;
    b = DW'((int'(a) + 1) * 32'h002F1A3D) ^ 24'h5A5A5A;
    return inv ? ~b : b;
  endfunction

  assign rd_data = reg_val(rd_addr, inv_sel);

  srl_read_port dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen(sen), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; wait_n(HALF);
    sclk = 1'b0; wait_n(HALF);
  endtask

  task automatic send_frame(input logic [7:0] bits, input int n);
    sen = 1'b1; wait_n(HALF);
    for (int i = 0; i < n; i++) begin
      sdio_in = bits[n-1-i];
      wait_n(4);
      pulse();
    end
    sen = 1'b0; wait_n(HALF);
  endtask

  task automatic read_tx(input logic [3:0] a, input bit inv);
    logic [DW-1:0] exp;
    bit valid;
    string tag;
    inv_sel = inv;
    valid = (a >= 4'd1) && (a <= 4'd7);
    exp = valid ? reg_val(a, inv) : '0;
    tag = valid ? "R5" : "R8";
    send_frame({3'b000, 1'b1, a}, 5);
    check(rd_addr == a, "R2 address", 32'(rd_addr), 32'(a));
    check(sdio_oe == 1'b0, "R3 line still input", 32'(sdio_oe), 0);
    for (int i = 0; i < DW; i++) begin
      pulse();
      check(sdio_oe == 1'b1, (i == 0) ? "R4 turnaround" : "R5 oe held", 32'(sdio_oe), 1);
      check(sdio_out == exp[DW-1-i], (i == 0) ? "R4 first bit" : tag, 32'(sdio_out), 32'(exp[DW-1-i]));
    end
    for (int k = 0; k < 2; k++) begin
      pulse();
      check(sdio_out == exp[0], "R6 hold last bit", 32'(sdio_out), 32'(exp[0]));
    end
    sen = 1'b1; wait_n(HALF);
    check(sdio_oe == 1'b1, "R7 oe during pulse", 32'(sdio_oe), 1);
    sen = 1'b0; wait_n(HALF);
    check(sdio_oe == 1'b0, "R7 released", 32'(sdio_oe), 0);
  endtask

  task automatic expect_no_read(input string req);
    for (int k = 0; k < 3; k++) begin
      pulse();
      check(sdio_oe == 1'b0, req, 32'(sdio_oe), 0);
    end
  endtask

  initial begin
    wait_n(5);
    check(sdio_oe == 1'b0 && sdio_out == 1'b0, "R1 reset state", {30'd0, sdio_oe, sdio_out}, 0);
    rst_n = 1'b1;
    wait_n(4);

    for (int inv = 0; inv < 2; inv++)
      for (int a = 0; a < 16; a++)
        read_tx(4'(a), bit'(inv));

    send_frame({3'b000, 1'b0, 4'd3}, 5);
    expect_no_read("R9 read flag clear");
    send_frame({4'b0000, 4'b1011}, 4);
    expect_no_read("R9 short frame");
    send_frame({2'b00, 6'b101101}, 6);
    expect_no_read("R9 long frame");
    read_tx(4'd5, 1'b0);

    send_frame({3'b000, 1'b1, 4'd6}, 5);
    for (int k = 0; k < 5; k++) pulse();
    check(sdio_oe == 1'b1, "R10 driving before reset", 32'(sdio_oe), 1);
    rst_n = 1'b0;
    #1;
    check(sdio_oe == 1'b0, "R10 async reset", 32'(sdio_oe), 0);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    read_tx(4'd2, 1'b1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule